// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is a single 16-bit down-counting timer channel. It advances one step on each clock cycle where the tick-enable input is high. A gate input either enables counting or retriggers the channel, depending on the mode. Six operating modes set the shape of the output: a latched terminal-count flag, a retriggerable one-shot, a periodic rate pulse, a square wave, and two single-tick strobes. One of the strobes is started by software and the other by the gate.

A load strobe supplies a new count and a 3-bit mode together. The channel restarts from that count on the next clock edge. The live count value is always visible on an output port. A snapshot request freezes a copy of that value for a host to read at its own pace. Byte sequencing, the host bus and decimal counting belong to the logic around the block.

Top module: `interval_counter`

## Requirements
- R1: A loaded value of 0 means a count of 65536. The live count then reads 0x0000, and the first tick takes it to 0xFFFF.
- R2: Mode codes 6 and 7 behave exactly like modes 2 and 3.
- R3: In modes 0 and 1, OUT is low after a load. It goes high once the number of ticks since the load reaches the count, and it stays high until the next load or restart.
- R4: In mode 2 the period is N ticks. On the tick that would take the count from 1 to 0, the counter reloads N and OUT goes high for one tick interval. The live count never reads zero unless N is 65536.
- R5: In mode 3 the period is N ticks. OUT is high while the phase inside the period is below (N+1)/2 ticks and low for the rest. This means OUT is high while the live count is greater than floor(N/2).
- R6: In modes 4 and 5, OUT is high only in the interval after the tick where the elapsed count equals N. The live count reads 0 during that interval. When the count later wraps, no second strobe occurs.
- R7: In modes 1, 2, 3 and 5, a rising edge on gate (gate sampled low on one clock edge and high on the next) restarts the count from N and clears OUT's one-shot state. It does not decrement on that edge.
- R8: In modes 0 and 4, gate low stops counting and a rising gate edge does not restart.
- R9: A load takes effect on the next clock edge. The live count equals the loaded value, and the mode given with the load takes over. A load overrides a restart and a tick in the same cycle.
- R10: After reset the channel is in mode 3 with N = 65536. The live count reads 0x0000, OUT is high and the snapshot reads 0.
- R11: The count changes only on cycles with tick-enable high, a load or a restart. In modes 0, 1, 4 and 5 it keeps decrementing modulo 65536 past terminal count.
- R12: A snapshot request captures the live count as it was before that clock edge. The snapshot holds that value until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable tick |
| gate_i | input | 1 | Gate level |
| load_i | input | 1 | Count-load strobe |
| load_val_i | input | 16 | Count to load (0 means 65536) |
| mode_i | input | 3 | Operating mode, sampled with load_i |
| snap_i | input | 1 | Snapshot request |
| out_o | output | 1 | Channel output level |
| count_o | output | 16 | Live count value |
| snap_o | output | 16 | Captured snapshot of the count |

## Verification
The checker watches several things on every cycle. A load lands the exact value on the count, and an idle cycle leaves the count unchanged. Mode 0 and 4 hold still while gate is low, and the mode 0 output stays high once set. A strobe is high only with the count at zero, the rate mode never shows zero, and the snapshot tracks the count of the previous cycle. Only the bench scenarios can show the waveform shapes over a whole period. These include the square-wave split for odd and even counts and the reload point of the rate mode. They also include the 65536 encoding, the mode aliases, retriggering in some modes but not others, and the absence of a second strobe after a full wrap.

// File: rtl/intv_pkg.sv
package intv_pkg;
  typedef enum logic [2:0] {
    M_TC_FLAG  = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SW_STRB  = 3'd4,
    M_HW_STRB  = 3'd5
  } mode_e;

  // codes 6/7 fold onto 2/3
  function automatic mode_e fold_mode(input logic [2:0] m);
    if (m[2:1] == 2'b11) return mode_e'({1'b0, m[1:0]});
    return mode_e'(m);
  endfunction

  function automatic logic is_periodic(input mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic gate_enables(input mode_e m);
    return (m == M_TC_FLAG) || (m == M_SW_STRB);
  endfunction
endpackage

// File: rtl/intv_gate_edge.sv
module intv_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic gate_q_o,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign gate_q_o = gate_q;
  assign rise_o   = gate_i & ~gate_q;
endmodule

// File: rtl/intv_core.sv
module intv_core
  import intv_pkg::*;
#(
  parameter int CW = 16,
  localparam int NW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  mode_e         load_mode_i,
  input  logic          restart_i,
  input  logic          step_i,
  output mode_e         mode_o,
  output logic [NW-1:0] cnt_o,
  output logic [NW-1:0] reload_o,
  output logic          expired_o,
  output logic          pulse_o
);
  localparam logic [NW-1:0] FULL = {1'b1, {CW{1'b0}}};
  localparam logic [NW-1:0] ONE  = NW'(1);

  mode_e         mode_q;
  logic [NW-1:0] cnt_q, reload_q;
  logic          expired_q, pulse_q;

  function automatic logic [NW-1:0] to_n(input logic [CW-1:0] v);
    return (v == '0) ? FULL : {1'b0, v};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_SQUARE;
      reload_q  <= FULL;
      cnt_q     <= FULL;
      expired_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else if (load_i) begin
      mode_q    <= load_mode_i;
      reload_q  <= to_n(load_val_i);
      cnt_q     <= to_n(load_val_i);
      expired_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else if (restart_i) begin
      cnt_q     <= reload_q;
      expired_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else if (step_i) begin
      if (is_periodic(mode_q)) begin
        if (cnt_q == ONE) begin
          cnt_q   <= reload_q;
          pulse_q <= 1'b1;
        end else begin
          cnt_q   <= cnt_q - ONE;
          pulse_q <= 1'b0;
        end
      end else begin
        cnt_q   <= {1'b0, cnt_q[CW-1:0] - CW'(1)};
        pulse_q <= (cnt_q == ONE) && !expired_q;
        if (cnt_q == ONE) expired_q <= 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign cnt_o     = cnt_q;
  assign reload_o  = reload_q;
  assign expired_o = expired_q;
  assign pulse_o   = pulse_q;
endmodule

// File: rtl/intv_out_dec.sv
module intv_out_dec
  import intv_pkg::*;
#(
  parameter int CW = 16,
  localparam int NW = CW + 1
) (
  input  mode_e         mode_i,
  input  logic [NW-1:0] cnt_i,
  input  logic [NW-1:0] reload_i,
  input  logic          expired_i,
  input  logic          pulse_i,
  output logic          out_o
);
  always_comb begin
    unique case (mode_i)
      M_TC_FLAG, M_ONESHOT: out_o = expired_i;
      M_SQUARE:             out_o = cnt_i > (reload_i >> 1);
      default:              out_o = pulse_i;
    endcase
  end
endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import intv_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [2:0]    mode_i,
  input  logic          snap_i,
  output logic          out_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] snap_o
);
  localparam int NW = CW + 1;

  mode_e         mode_q;
  logic [NW-1:0] cnt_q, reload_q;
  logic          expired_q, pulse_q;
  logic          gate_q, gate_rise, restart, step;
  logic [CW-1:0] snap_q;

  intv_gate_edge u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gate_i   (gate_i),
    .gate_q_o (gate_q),
    .rise_o   (gate_rise)
  );

  assign restart = gate_rise & ~gate_enables(mode_q) & (mode_q != M_TC_FLAG);
  assign step    = tick_i & (gate_i | ~gate_enables(mode_q));

  intv_core #(.CW(CW)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_val_i  (load_val_i),
    .load_mode_i (fold_mode(mode_i)),
    .restart_i   (restart),
    .step_i      (step),
    .mode_o      (mode_q),
    .cnt_o       (cnt_q),
    .reload_o    (reload_q),
    .expired_o   (expired_q),
    .pulse_o     (pulse_q)
  );

  intv_out_dec #(.CW(CW)) u_dec (
    .mode_i    (mode_q),
    .cnt_i     (cnt_q),
    .reload_i  (reload_q),
    .expired_i (expired_q),
    .pulse_i   (pulse_q),
    .out_o     (out_o)
  );

  assign count_o = cnt_q[CW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (snap_i) snap_q <= count_o;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/interval_counter_chk.sv
module interval_counter_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          gate_i,
  input logic          load_i,
  input logic [CW-1:0] load_val_i,
  input logic          snap_i,
  input logic          out_o,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] snap_o,
  input logic [2:0]    mode_q,
  input logic          gate_q,
  input logic [CW:0]   reload_q
);
  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !(gate_i && !gate_q)) |=> $stable(count_o)); // R11

  AST_GATE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == 3'd0 || mode_q == 3'd4) && !gate_i && !load_i) |=> $stable(count_o)); // R8

  AST_RATE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd2 && reload_q[CW-1:0] != '0) |-> count_o != '0); // R4

  AST_STROBE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == 3'd4 || mode_q == 3'd5) && out_o) |-> count_o == '0); // R6

  AST_TC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd0 && out_o && !load_i) |=> out_o); // R3

  AST_SNAP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> snap_o == $past(count_o)); // R12
endmodule

bind interval_counter interval_counter_chk #(.CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .gate_i     (gate_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .snap_i     (snap_i),
  .out_o      (out_o),
  .count_o    (count_o),
  .snap_o     (snap_o),
  .mode_q     (mode_q),
  .gate_q     (gate_q),
  .reload_q   (reload_q)
);

// File: tb/interval_counter_test.sv
module interval_counter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b1;
  logic        load_i = 1'b0;
  logic [15:0] load_val_i = '0;
  logic [2:0]  mode_i = '0;
  logic        snap_i = 1'b0;
  logic        out_o;
  logic [15:0] count_o, snap_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  interval_counter uut (
    .clk_i, .rst_ni, .tick_i, .gate_i, .load_i, .load_val_i,
    .mode_i, .snap_i, .out_o, .count_o, .snap_o
  );

  typedef struct packed {
    logic [2:0]  m;
    logic [15:0] n;
    logic [15:0] d;
    logic [15:0] c;
    logic        o;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 16'd5, 16'd3, 16'd2,      1'b0},
    '{3'd0, 16'd5, 16'd5, 16'd0,      1'b1},
    '{3'd0, 16'd5, 16'd7, 16'hFFFE,   1'b1},
    '{3'd1, 16'd4, 16'd2, 16'd2,      1'b0},
    '{3'd1, 16'd4, 16'd4, 16'd0,      1'b1},
    '{3'd2, 16'd4, 16'd3, 16'd1,      1'b0},
    '{3'd2, 16'd4, 16'd4, 16'd4,      1'b1},
    '{3'd2, 16'd4, 16'd5, 16'd3,      1'b0},
    '{3'd3, 16'd6, 16'd2, 16'd4,      1'b1},
    '{3'd3, 16'd6, 16'd3, 16'd3,      1'b0},
    '{3'd3, 16'd5, 16'd3, 16'd2,      1'b0},
    '{3'd3, 16'd5, 16'd5, 16'd5,      1'b1},
    '{3'd4, 16'd3, 16'd3, 16'd0,      1'b1},
    '{3'd4, 16'd3, 16'd4, 16'hFFFF,   1'b0},
    '{3'd5, 16'd3, 16'd2, 16'd1,      1'b0},
    '{3'd6, 16'd4, 16'd4, 16'd4,      1'b1},
    '{3'd7, 16'd6, 16'd3, 16'd3,      1'b0}
  };

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0, 3'd1: return "R3";
      3'd2:       return "R4";
      3'd3:       return "R5";
      3'd4, 3'd5: return "R6";
      default:    return "R2";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    @(negedge clk_i);
    load_i = 1'b1; mode_i = m; load_val_i = v;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    if (n > 0) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      repeat (n) @(posedge clk_i);
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic gate_pulse();
    @(negedge clk_i); gate_i = 1'b0;
    @(negedge clk_i); gate_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    check("R10", "count", count_o, 16'h0000);
    check("R10", "out", out_o, 1'b1);
    check("R10", "snap", snap_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      do_load(TBL[i].m, TBL[i].n);
      do_ticks(int'(TBL[i].d));
      check(tag_of(TBL[i].m), "count", count_o, TBL[i].c);
      check(tag_of(TBL[i].m), "out", out_o, TBL[i].o);
    end

    // R1 zero means 65536
    do_load(3'd0, 16'd0);
    check("R1", "count_after_load", count_o, 16'h0000);
    do_ticks(1);
    check("R1", "count", count_o, 16'hFFFF);
    check("R1", "out", out_o, 1'b0);
    do_load(3'd2, 16'd0);
    do_ticks(1);
    check("R1", "rate_count", count_o, 16'hFFFF);

    // R4 count of one in rate mode
    do_load(3'd2, 16'd1);
    do_ticks(3);
    check("R4", "n1_count", count_o, 16'd1);
    check("R4", "n1_out", out_o, 1'b1);

    // R8 gate disables mode 0
    @(negedge clk_i); gate_i = 1'b0;
    do_load(3'd0, 16'd5);
    do_ticks(3);
    check("R8", "gated_count", count_o, 16'd5);
    @(negedge clk_i); gate_i = 1'b1;
    do_ticks(2);
    check("R8", "resumed_count", count_o, 16'd3);
    // R8 no retrigger in mode 4
    do_load(3'd4, 16'd5);
    do_ticks(2);
    gate_pulse();
    check("R8", "m4_no_restart", count_o, 16'd3);

    // R7 retrigger mode 1
    do_load(3'd1, 16'd6);
    do_ticks(4);
    gate_pulse();
    check("R7", "m1_restart_count", count_o, 16'd6);
    check("R7", "m1_restart_out", out_o, 1'b0);
    do_ticks(6);
    check("R7", "m1_fire_out", out_o, 1'b1);
    // R7 retrigger mode 2
    do_load(3'd2, 16'd8);
    do_ticks(3);
    gate_pulse();
    check("R7", "m2_restart_count", count_o, 16'd8);

    // R6 no second strobe after wrap
    do_load(3'd5, 16'd2);
    do_ticks(2);
    check("R6", "m5_strobe", out_o, 1'b1);
    do_ticks(65536);
    check("R6", "wrap_count", count_o, 16'd0);
    check("R6", "wrap_no_strobe", out_o, 1'b0);
    gate_pulse();
    check("R7", "m5_restart_count", count_o, 16'd2);
    check("R7", "m5_restart_out", out_o, 1'b0);

    // R9 mid-count reload with mode change
    do_load(3'd2, 16'd10);
    do_ticks(3);
    check("R9", "before_reload", count_o, 16'd7);
    do_load(3'd0, 16'd3);
    check("R9", "reload_count", count_o, 16'd3);
    check("R9", "reload_out", out_o, 1'b0);
    do_ticks(3);
    check("R9", "new_mode_out", out_o, 1'b1);

    // R11 no tick, no change
    do_load(3'd3, 16'd6);
    repeat (5) @(negedge clk_i);
    check("R11", "idle_count", count_o, 16'd6);

    // R12 snapshot
    do_load(3'd0, 16'd100);
    do_ticks(10);
    @(negedge clk_i); snap_i = 1'b1;
    @(negedge clk_i); snap_i = 1'b0;
    check("R12", "snap", snap_o, 16'd90);
    do_ticks(5);
    check("R12", "snap_hold", snap_o, 16'd90);
    check("R12", "live", count_o, 16'd85);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule